// File: doc/BRIEF.md
# Linked-Descriptor Memory Mover

This block moves data between system memory and a word stream under the control of descriptors that software leaves in memory. Each descriptor is four 32-bit words: a control word, a byte count, a buffer address and a link address, read in that order from consecutive word addresses. The engine fetches a descriptor through a single-word memory request/response port and checks that it may use it. It then copies the buffer to the outgoing stream (toward the card) or from the incoming stream into memory. When the buffer is done it writes the control word back with the ownership flag cleared, so the descriptor returns to software.

After each descriptor the engine follows the link word (chained mode), returns to the base address (end-of-ring flag) or steps 16 bytes forward. It stops after a descriptor flagged as last. Sticky status flags record completion and fault events and are cleared by writing ones. The status word also carries a summary of normal and abnormal events and the current sequencer state code.

Both streams use valid/ready. On the outgoing stream, `tx_valid` and `tx_data` hold steady until `tx_ready` is seen, and the sink may stall for any number of cycles. On the incoming stream, `rx_ready` is high only while the engine waits for a word, and a word transfers on any cycle where `rx_valid` and `rx_ready` are both high. On the memory request port, a request holds its address and data until `mem_req_ready`. A read returns its word on a later `mem_rsp_valid` cycle, with one read outstanding at a time. Writes get no response.

Top module: `chain_dma`

## Requirements
- R1: After reset the status word is zero, `irq` is low, and no memory request, outgoing word or incoming-ready is asserted.
- R2: On `start` while enabled and idle, the engine reads the four descriptor words at `desc_base`+0, +4, +8 and +12, in that order, each read issued only after the previous response.
- R3: A descriptor whose control bit 31 (owned by engine) is 0 sets status bit 4 and parks the sequencer in code 1 (suspend). A later `start` re-reads the same descriptor address.
- R4: When `xfer_to_card` is 1, the buffer words are read in ascending address order and presented on the outgoing stream. `tx_valid`/`tx_data` stay stable while `tx_ready` is low.
- R5: When `xfer_to_card` is 0, words accepted from the incoming stream are written to ascending buffer addresses, one per incoming word.
- R6: The byte-count field is word 1 bits 12:0, and the value 0 stands for 8192 bytes.
- R7: Closing a descriptor writes its control word back to the descriptor address with bit 31 cleared, other bits kept, and bit 30 set if `card_err` pulsed during that descriptor. A `card_err` pulse also sets status bit 5.
- R8: Closing sets status bit 0 (outgoing) or bit 1 (incoming). If control bit 1 (interrupt suppress) is set, the flag is set only when control bit 2 (last) is also set.
- R9: After a non-last descriptor, the next address is word 3 if control bit 4 (chained) is set, else `desc_base` if bit 5 (end of ring) is set, else the descriptor address plus 16. After a last descriptor the sequencer returns to code 0 (idle).
- R10: A buffer address or byte count that is not a multiple of 4 sets status bit 2 and returns to idle without moving data or writing back.
- R11: Status flags are cleared by a one in the matching bit of `sts_w1c`. Bit 8 is the OR of bits 0 and 1, bit 9 is the OR of bits 2, 4, 5 and 10, and `irq` is the OR of bits 8 and 9.
- R12: A `host_abort` pulse while busy returns the sequencer to idle on the next cycle and sets status bit 10.
- R13: A `mode_srst` pulse clears all status flags and idles the engine. While `mode_en` is low, `start` has no effect and no memory request is made.
- R14: Status bits 16:13 hold the sequencer state code: 0 idle, 1 suspend, 2 descriptor read, 3 descriptor check, 4 read-request wait, 5 write-request wait, 6 read, 7 write, 8 descriptor close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Engine enable; low forces idle |
| mode_srst | input | 1 | Soft reset pulse |
| start | input | 1 | Begin from base when idle, or re-read the descriptor when suspended |
| host_abort | input | 1 | Abort the transfer in progress |
| card_err | input | 1 | Card-side error pulse |
| xfer_to_card | input | 1 | 1: memory to outgoing stream, 0: incoming stream to memory |
| desc_base | input | 32 | First descriptor address, also the ring wrap target |
| sts_w1c | input | 32 | Write-one-to-clear for status flags, one cycle |
| status | output | 32 | Flags, summaries and state code |
| irq | output | 1 | Any summary set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Outgoing word taken |
| tx_data | output | 32 | Outgoing word |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Engine takes an incoming word |
| rx_data | input | 32 | Incoming word |

## Verification
The sequencer code in `status` moves on the clock edge that completes a handshake, so it is visible one cycle after that handshake. Status flags are set by registered events, one cycle after the state change that raised them. An abort shows as idle one cycle after the pulse and as bit 10 one cycle later. A clear by `sts_w1c` shows on the next cycle. The bench drives inputs and samples on the falling edge. For each job it waits until the state code reads idle or suspend and then waits two more cycles before reading flags, word counts and written-back descriptors.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SUSP  = 4'd1,
    ST_DREAD = 4'd2,
    ST_DCHK  = 4'd3,
    ST_RDREQ = 4'd4,
    ST_WRREQ = 4'd5,
    ST_READ  = 4'd6,
    ST_WRITE = 4'd7,
    ST_CLOSE = 4'd8
  } cdma_state_e;

  // control word flag positions
  localparam int unsigned CW_OWN = 31;
  localparam int unsigned CW_CES = 30;
  localparam int unsigned CW_ER  = 5;
  localparam int unsigned CW_CH  = 4;
  localparam int unsigned CW_LD  = 2;
  localparam int unsigned CW_DIC = 1;

  // status word positions
  localparam int unsigned SB_TX    = 0;
  localparam int unsigned SB_RX    = 1;
  localparam int unsigned SB_FATAL = 2;
  localparam int unsigned SB_UNAV  = 4;
  localparam int unsigned SB_CES   = 5;
  localparam int unsigned SB_NRM   = 8;
  localparam int unsigned SB_ABN   = 9;
  localparam int unsigned SB_ABORT = 10;
  localparam int unsigned SB_STATE = 13;

  typedef struct packed {
    logic tx;
    logic rx;
    logic fatal;
    logic unav;
    logic ces;
    logic abort;
  } cdma_evt_t;

endpackage

// File: rtl/cdma_walker.sv
module cdma_walker
  import cdma_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SZ_BITS = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          enable,
  input  logic          start,
  input  logic          abort,
  input  logic          card_err,
  input  logic          tx_dir,
  input  logic [DW-1:0] base,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic [3:0]    state_code,
  output cdma_evt_t     evt
);

  localparam int LENW = SZ_BITS + 1;
  localparam logic [LENW-1:0] WORD_B = LENW'(4);
  localparam logic [LENW-1:0] MAX_B  = LENW'(1) << SZ_BITS;

  cdma_state_e     state;
  logic [DW-1:0]   desc_addr, buf_addr, nxt_ptr, cfg_w, data_q;
  logic [LENW-1:0] remain;
  logic [1:0]      widx;
  logic            req_pend, data_full, ces_seen;
  logic [DW-1:0]   wb_word;

  assign wb_word    = {1'b0, cfg_w[CW_CES] | ces_seen, cfg_w[DW-3:0]};
  assign state_code = state;
  assign tx_data    = data_q;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = desc_addr;
    mem_req_wdata = data_q;
    tx_valid      = 1'b0;
    rx_ready      = 1'b0;
    case (state)
      ST_DREAD: begin
        mem_req_valid = !req_pend;
        mem_req_addr  = desc_addr + DW'({widx, 2'b00});
      end
      ST_RDREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = buf_addr;
      end
      ST_READ:  tx_valid = data_full;
      ST_WRREQ: rx_ready = 1'b1;
      ST_WRITE: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = buf_addr;
      end
      ST_CLOSE: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      desc_addr <= '0;
      buf_addr  <= '0;
      nxt_ptr   <= '0;
      cfg_w     <= '0;
      data_q    <= '0;
      remain    <= '0;
      widx      <= '0;
      req_pend  <= 1'b0;
      data_full <= 1'b0;
      ces_seen  <= 1'b0;
      evt       <= '0;
    end else begin
      evt <= '0;
      if (srst || !enable) begin
        state     <= ST_IDLE;
        req_pend  <= 1'b0;
        data_full <= 1'b0;
      end else if (abort && state != ST_IDLE) begin
        state     <= ST_IDLE;
        req_pend  <= 1'b0;
        data_full <= 1'b0;
        evt.abort <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            desc_addr <= base;
            widx      <= '0;
            req_pend  <= 1'b0;
            state     <= ST_DREAD;
          end
          ST_SUSP: if (start) begin
            widx     <= '0;
            req_pend <= 1'b0;
            state    <= ST_DREAD;
          end
          ST_DREAD: begin
            if (!req_pend && mem_req_ready) req_pend <= 1'b1;
            if (req_pend && mem_rsp_valid) begin
              case (widx)
                2'd0: cfg_w <= mem_rsp_rdata;
                2'd1: remain <= (mem_rsp_rdata[SZ_BITS-1:0] == '0) ? MAX_B
                              : {1'b0, mem_rsp_rdata[SZ_BITS-1:0]};
                2'd2: buf_addr <= mem_rsp_rdata;
                default: nxt_ptr <= mem_rsp_rdata;
              endcase
              req_pend <= 1'b0;
              widx     <= widx + 2'd1;
              if (widx == 2'd3) state <= ST_DCHK;
            end
          end
          ST_DCHK: begin
            ces_seen <= 1'b0;
            if (!cfg_w[CW_OWN]) begin
              evt.unav <= 1'b1;
              state    <= ST_SUSP;
            end else if (buf_addr[1:0] != 2'b00 || remain[1:0] != 2'b00) begin
              evt.fatal <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= tx_dir ? ST_RDREQ : ST_WRREQ;
            end
          end
          ST_RDREQ: if (mem_req_ready) begin
            req_pend <= 1'b1;
            state    <= ST_READ;
          end
          ST_READ: begin
            if (req_pend && mem_rsp_valid) begin
              data_q    <= mem_rsp_rdata;
              data_full <= 1'b1;
              req_pend  <= 1'b0;
            end
            if (data_full && tx_ready) begin
              data_full <= 1'b0;
              buf_addr  <= buf_addr + DW'(4);
              remain    <= remain - WORD_B;
              state     <= (remain == WORD_B) ? ST_CLOSE : ST_RDREQ;
            end
          end
          ST_WRREQ: if (rx_valid) begin
            data_q <= rx_data;
            state  <= ST_WRITE;
          end
          ST_WRITE: if (mem_req_ready) begin
            buf_addr <= buf_addr + DW'(4);
            remain   <= remain - WORD_B;
            state    <= (remain == WORD_B) ? ST_CLOSE : ST_WRREQ;
          end
          ST_CLOSE: if (mem_req_ready) begin
            if (!cfg_w[CW_DIC] || cfg_w[CW_LD]) begin
              if (tx_dir) evt.tx <= 1'b1;
              else        evt.rx <= 1'b1;
            end
            if (cfg_w[CW_LD]) begin
              state <= ST_IDLE;
            end else begin
              desc_addr <= cfg_w[CW_CH] ? nxt_ptr
                         : cfg_w[CW_ER] ? base : desc_addr + DW'(16);
              widx      <= '0;
              state     <= ST_DREAD;
            end
          end
          default: state <= ST_IDLE;
        endcase
        if (card_err && state != ST_IDLE) begin
          ces_seen <= 1'b1;
          evt.ces  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cdma_status.sv
module cdma_status
  import cdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  cdma_evt_t     evt,
  input  logic [DW-1:0] w1c,
  input  logic [SW-1:0] state_code,
  output logic [DW-1:0] status,
  output logic          irq
);

  localparam logic [DW-1:0] STICKY = (DW'(1) << SB_TX) | (DW'(1) << SB_RX)
                                   | (DW'(1) << SB_FATAL) | (DW'(1) << SB_UNAV)
                                   | (DW'(1) << SB_CES) | (DW'(1) << SB_ABORT);

  logic [DW-1:0] flags_q, set_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[SB_TX]    = evt.tx;
    set_vec[SB_RX]    = evt.rx;
    set_vec[SB_FATAL] = evt.fatal;
    set_vec[SB_UNAV]  = evt.unav;
    set_vec[SB_CES]   = evt.ces;
    set_vec[SB_ABORT] = evt.abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (srst) flags_q <= '0;
    else           flags_q <= ((flags_q & ~w1c) | set_vec) & STICKY;
  end

  always_comb begin
    status         = flags_q;
    status[SB_NRM] = flags_q[SB_TX] | flags_q[SB_RX];
    status[SB_ABN] = flags_q[SB_FATAL] | flags_q[SB_UNAV]
                   | flags_q[SB_CES] | flags_q[SB_ABORT];
    status[SB_STATE +: SW] = state_code;
  end

  assign irq = status[SB_NRM] | status[SB_ABN];

endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import cdma_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SZ_BITS = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          mode_srst,
  input  logic          start,
  input  logic          host_abort,
  input  logic          card_err,
  input  logic          xfer_to_card,
  input  logic [DW-1:0] desc_base,
  input  logic [DW-1:0] sts_w1c,
  output logic [DW-1:0] status,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data
);

  localparam int SW = 4;

  logic [SW-1:0] state_code;
  cdma_evt_t     evt;

  cdma_walker #(.DW(DW), .SZ_BITS(SZ_BITS)) u_walk (
    .clk(clk), .rst_n(rst_n), .srst(mode_srst), .enable(mode_en),
    .start(start), .abort(host_abort), .card_err(card_err),
    .tx_dir(xfer_to_card), .base(desc_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .state_code(state_code), .evt(evt)
  );

  cdma_status #(.DW(DW), .SW(SW)) u_stat (
    .clk(clk), .rst_n(rst_n), .srst(mode_srst), .evt(evt),
    .w1c(sts_w1c), .state_code(state_code), .status(status), .irq(irq)
  );

endmodule

// File: rtl/cdma_checker.sv
module cdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_en,
  input logic        mode_srst,
  input logic        host_abort,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic [31:0] status
);

  logic [3:0] st;
  assign st = status[16:13];

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st <= 4'd8); // R14

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0) |-> (!mem_req_valid && !tx_valid)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk)
    disable iff (!rst_n || mode_srst || host_abort || !mode_en)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

  AST_TX_HOLD: assert property (@(posedge clk)
    disable iff (!rst_n || mode_srst || host_abort || !mode_en)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R4

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && st == 4'd8) |-> !mem_req_wdata[31]); // R7

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n || mode_srst)
    (host_abort && st != 4'd0) |=> (st == 4'd0)); // R12

endmodule

bind chain_dma cdma_checker u_chk (.*);

// File: tb/chain_dma_tb.sv
`timescale 1ns/1ps
module chain_dma_tb;

  localparam logic [31:0] OWN = 32'h8000_0000, CES = 32'h4000_0000;
  localparam logic [31:0] ER = 32'h20, CH = 32'h10, FD = 32'h8, LD = 32'h4, DIC = 32'h2;

  typedef struct packed {
    logic        tx;
    logic        dic;
    logic        slow;
    logic [12:0] size;
    logic [1:0]  irq;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 1'b0, 13'd16, 2'b01},
    '{1'b0, 1'b0, 1'b0, 13'd32, 2'b10},
    '{1'b1, 1'b1, 1'b0, 13'd64, 2'b01},
    '{1'b0, 1'b1, 1'b0, 13'd8,  2'b10},
    '{1'b1, 1'b0, 1'b1, 13'd12, 2'b01},
    '{1'b0, 1'b0, 1'b1, 13'd20, 2'b10}
  };

  logic clk = 0, rst_n = 0;
  logic mode_en = 1, mode_srst = 0, start = 0, host_abort = 0, card_err = 0, xfer_to_card = 1;
  logic [31:0] desc_base = 0, sts_w1c = 0;
  logic [31:0] status, mem_req_addr, mem_req_wdata, mem_rsp_rdata, tx_data, rx_data;
  logic irq, mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic tx_valid, tx_ready, rx_valid, rx_ready;

  logic [31:0] mem [0:4095];
  int unsigned cyc = 0, tx_cnt = 0, tx_bad = 0, tx_exp = 0, rx_cnt = 0, req_seen = 0, rd_n = 0;
  logic [31:0] rd_log [0:7];
  logic stall = 0, bp = 0, rx_on = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  assign mem_req_ready = !stall || cyc[0];
  assign tx_ready      = !bp || cyc[1];
  assign rx_valid      = rx_on;
  assign rx_data       = 32'hC300_0000 | rx_cnt;

  chain_dma u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) req_seen <= req_seen + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[13:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[13:2]];
        if (rd_n < 8) rd_log[rd_n] <= mem_req_addr;
        rd_n <= rd_n + 1;
      end
    end
    if (tx_valid && tx_ready) begin
      if (tx_data != (32'hA500_0000 | tx_exp)) tx_bad <= tx_bad + 1;
      tx_exp <= tx_exp + 1;
      tx_cnt <= tx_cnt + 1;
    end
    if (rx_valid && rx_ready) rx_cnt <= rx_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_data();
    for (int i = 1024; i < 4096; i++) mem[i] = 32'hA500_0000 | i;
  endtask

  task automatic put_desc(input logic [31:0] a, cw, sz, bufa, nx);
    mem[a[13:2]] = cw; mem[a[13:2]+1] = sz; mem[a[13:2]+2] = bufa; mem[a[13:2]+3] = nx;
  endtask

  task automatic prep(input logic [31:0] base, input logic tx, input logic [31:0] first_buf);
    desc_base = base; xfer_to_card = tx;
    tx_cnt = 0; tx_bad = 0; tx_exp = first_buf >> 2; rx_cnt = 0; rd_n = 0;
  endtask

  task automatic kick();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end
    while (status[16:13] > 4'd1 && n < 20000);
    if (n >= 20000) chk("watchdog", status, 32'h0);
    repeat (2) @(negedge clk);
    rx_on = 0;
  endtask

  task automatic clear_all();
    @(negedge clk) sts_w1c = 32'hFFFF_FFFF;
    @(negedge clk) sts_w1c = 32'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mism;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h0);
    chk("R1 outputs", {31'h0, mem_req_valid | tx_valid | rx_ready | irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // table of single-descriptor jobs
    for (int v = 0; v < 6; v++) begin
      fill_data();
      put_desc(32'h100, OWN | LD | FD | (VEC[v].dic ? DIC : 32'h0),
               {19'h0, VEC[v].size}, 32'h1000, 32'h0);
      prep(32'h100, VEC[v].tx, 32'h1000);
      stall = VEC[v].slow; bp = VEC[v].slow; rx_on = !VEC[v].tx;
      kick();
      wait_done();
      if (VEC[v].tx) begin
        chk("R4 word count", tx_cnt, 32'(VEC[v].size / 4));
        chk("R4 word data", tx_bad, 0);
      end else begin
        mism = 0;
        for (int k = 0; k < VEC[v].size / 4; k++)
          if (mem[1024 + k] != (32'hC300_0000 | k)) mism++;
        chk("R5 word count", rx_cnt, 32'(VEC[v].size / 4));
        chk("R5 word data", mism, 0);
      end
      chk("R7 writeback", mem[32'h40], LD | FD | (VEC[v].dic ? DIC : 32'h0));
      chk("R8 irq flags", {30'h0, status[1:0]}, {30'h0, VEC[v].irq});
      chk("R14 idle code", {28'h0, status[16:13]}, 32'h0);
      chk("R11 normal summary", {31'h0, status[8] & irq}, 32'h1);
      clear_all();
      chk("R11 w1c clears", status, 32'h0);
    end
    stall = 0; bp = 0;

    // R2 fetch order and R10 unaligned address
    put_desc(32'h700, OWN | LD, 32'd8, 32'h1002, 32'h0);
    prep(32'h700, 1, 32'h1000);
    kick(); wait_done();
    chk("R2 fetch addr0", rd_log[0], 32'h700);
    chk("R2 fetch addr1", rd_log[1], 32'h704);
    chk("R2 fetch addr2", rd_log[2], 32'h708);
    chk("R2 fetch addr3", rd_log[3], 32'h70C);
    chk("R10 fatal flag", {31'h0, status[2]}, 32'h1);
    chk("R10 idle, no data", {status[16:13], tx_cnt[27:0]}, 32'h0);
    chk("R10 no writeback", mem[32'h1C0], OWN | LD);
    chk("R11 abnormal summary", {31'h0, status[9]}, 32'h1);
    clear_all();
    put_desc(32'h700, OWN | LD, 32'd6, 32'h1000, 32'h0);
    kick(); wait_done();
    chk("R10 odd size", {31'h0, status[2]}, 32'h1);
    clear_all();

    // R6 size zero means 8192 bytes
    fill_data();
    put_desc(32'h100, OWN | LD, 32'd0, 32'h1000, 32'h0);
    prep(32'h100, 1, 32'h1000);
    kick(); wait_done();
    chk("R6 max length words", tx_cnt, 32'd2048);
    chk("R6 data", tx_bad, 0);
    clear_all();

    // R9 chained: link word followed, suppressed irq still raised on last (R8)
    put_desc(32'h100, OWN | CH | DIC | FD, 32'd8, 32'h1000, 32'h200);
    put_desc(32'h200, OWN | LD | DIC, 32'd8, 32'h1008, 32'h0);
    prep(32'h100, 1, 32'h1000);
    kick(); wait_done();
    chk("R9 chained words", tx_cnt, 32'd4);
    chk("R9 chained data", tx_bad, 0);
    chk("R9 second writeback", mem[32'h80], LD | DIC);
    chk("R8 last with suppress", {31'h0, status[0]}, 32'h1);
    clear_all();

    // R9 sequential: +16 when neither chained nor ring
    put_desc(32'h300, OWN, 32'd4, 32'h1000, 32'h999);
    put_desc(32'h310, OWN | LD, 32'd4, 32'h1004, 32'h0);
    prep(32'h300, 1, 32'h1000);
    kick(); wait_done();
    chk("R9 sequential words", tx_cnt, 32'd2);
    chk("R9 sequential writeback", mem[32'hC4], LD);
    chk("R9 sequential idle", {28'h0, status[16:13]}, 32'h0);
    clear_all();

    // R9 ring wraps to base; returned descriptor then unavailable (R3)
    put_desc(32'h400, OWN | ER, 32'd4, 32'h1000, 32'h0);
    prep(32'h400, 1, 32'h1000);
    kick(); wait_done();
    chk("R9 ring words", tx_cnt, 32'd1);
    chk("R3 suspend code", {28'h0, status[16:13]}, 32'h1);
    chk("R3 unavailable flag", {31'h0, status[4]}, 32'h1);
    chk("R8 flag without suppress", {31'h0, status[0]}, 32'h1);
    @(negedge clk) mode_srst = 1;
    @(negedge clk) mode_srst = 0;
    clear_all();

    // R8 suppressed on non-last, then R3 resume
    put_desc(32'h500, OWN | CH | DIC, 32'd4, 32'h1000, 32'h600);
    put_desc(32'h600, 32'h0, 32'd4, 32'h1004, 32'h0);
    prep(32'h500, 1, 32'h1000);
    kick(); wait_done();
    chk("R8 suppressed", {31'h0, status[0]}, 32'h0);
    chk("R3 parked", {27'h0, status[4], status[16:13]}, 32'h11);
    clear_all();
    mem[32'h180] = OWN | LD;
    kick(); wait_done();
    chk("R3 resumed words", tx_cnt, 32'd2);
    chk("R3 resumed idle", {31'h0, status[0]}, 32'h1);
    chk("R3 resumed code", {28'h0, status[16:13]}, 32'h0);
    clear_all();

    // R7 card error summary into writeback
    put_desc(32'h100, OWN | LD, 32'd64, 32'h1000, 32'h0);
    prep(32'h100, 0, 32'h1000);
    stall = 1; rx_on = 1;
    kick();
    repeat (30) @(negedge clk);
    card_err = 1;
    @(negedge clk) card_err = 0;
    wait_done();
    stall = 0;
    chk("R7 CES writeback", mem[32'h40], CES | LD);
    chk("R7 CES flag", {31'h0, status[5]}, 32'h1);
    clear_all();

    // R12 abort mid transfer
    put_desc(32'h100, OWN | LD, 32'd1024, 32'h1000, 32'h0);
    prep(32'h100, 1, 32'h1000);
    bp = 1;
    kick();
    repeat (30) @(negedge clk);
    host_abort = 1;
    @(negedge clk) host_abort = 0;
    chk("R12 idle next cycle", {28'h0, status[16:13]}, 32'h0);
    @(negedge clk);
    chk("R12 abort flag", {30'h0, status[10], status[9]}, 32'h3);
    bp = 0;

    // R13 soft reset clears flags
    @(negedge clk) mode_srst = 1;
    @(negedge clk) mode_srst = 0;
    chk("R13 srst clears", status, 32'h0);

    // R13 disabled: start ignored
    mode_en = 0;
    @(negedge clk) req_seen = 0;
    kick();
    repeat (10) @(negedge clk);
    chk("R13 no requests", req_seen, 32'h0);
    chk("R13 still idle", status, 32'h0);
    mode_en = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule